// File: doc/BRIEF.md
# In-Band Line Loopback Code Unit

This block sends and recognises the repeating in-band codes that ask a far-end T1 terminal to close or open a line loopback on a superframe link. On the transmit side a 2-bit mode input chooses one of four behaviours. The outgoing bit stream can pass through untouched. It can pass through while a payload-loopback request level is raised. It can also be replaced, bit by bit, with one of two repeating patterns: a five-bit activate pattern or a three-bit deactivate pattern. Each pattern advances one position per transmit bit strobe and starts again from its first position whenever the mode changes.

On the receive side two matchers run side by side, one tuned to each pattern length. A matcher counts a received bit as in-pattern when the newest bits, taken over one pattern length, hold exactly one 1. A code is declared only after a long unbroken run of in-pattern bits. It is withdrawn after a fixed number of consecutive out-of-pattern bits. At most one of the two declarations reaches the outputs at any time.

Top module: `lbc_loop_code`

## Requirements
- R1: While reset is asserted and on the first cycle after it, act_detect and deact_detect are 0 and, with mode 00, tx_bit_out equals tx_bit_in.
- R2: Mode 00 (normal) passes tx_bit_in to tx_bit_out combinationally and holds payload_lb at 0.
- R3: Mode 01 (payload loopback) passes tx_bit_in to tx_bit_out and holds payload_lb at 1.
- R4: Mode 10 (activate) drives tx_bit_out with the sequence 0,0,0,0,1 repeated; the position advances only on a cycle with tx_strobe high.
- R5: Mode 11 (deactivate) drives tx_bit_out with the sequence 0,0,1 repeated, advancing only on tx_strobe.
- R6: In the cycle where the mode differs from the mode of the previous cycle (mode 00 is assumed during reset), the pattern restarts at its first position, so a code mode outputs 0 in that cycle.
- R7: A received bit (rx_strobe high) is in-pattern for length L (5 for activate, 3 for deactivate) when it and the L-1 previously received bits contain exactly one 1; after reset the previous bits are taken to be all 1.
- R8: A code is declared in the cycle after its MIN_RUN_BITS-th consecutive in-pattern bit (default 5000).
- R9: A declared code is withdrawn in the cycle after DROP_MISSES (default 16) consecutive out-of-pattern bits; any in-pattern bit restarts that count, and any out-of-pattern bit restarts the declaration run.
- R10: act_detect and deact_detect are never both 1; when both codes are declared internally, only act_detect is raised.
- R11: Cycles with rx_strobe low change neither detection output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_ctrl | input | 2 | Loopback mode: 00 normal, 01 payload, 10 activate code, 11 deactivate code |
| tx_strobe | input | 1 | Transmit bit strobe |
| tx_bit_in | input | 1 | Outgoing bit before code insertion |
| tx_bit_out | output | 1 | Outgoing bit after code insertion |
| payload_lb | output | 1 | Payload loopback request level |
| rx_strobe | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Received bit |
| act_detect | output | 1 | Activate code declared |
| deact_detect | output | 1 | Deactivate code declared |

## Verification
The bench drives mode changes between strobes and back to back, where a generator that keeps its old phase would emit a 1 too early or a stretched run of zeros. It sends exactly DROP_MISSES-1 and then DROP_MISSES bad bits after a declaration, so an off-by-one miss counter would drop the code one bit early or late. It lets the deactivate code stay declared while an activate stream arrives, because the three-bit matcher keeps matching that stream; a design without priority would raise both outputs. Sparse strobes and periodic single errors check that idle cycles freeze the matchers and that an error restarts the declaration run.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [1:0] {
    LB_NORMAL  = 2'b00,
    LB_PAYLOAD = 2'b01,
    LB_ARM     = 2'b10,
    LB_DISARM  = 2'b11
  } lb_mode_e;

  localparam int ARM_LEN    = 5;
  localparam int DISARM_LEN = 3;
  localparam int PH_W       = $clog2(ARM_LEN);

  // Last index of the pattern picked by the mode's low bit.
  function automatic logic [PH_W-1:0] last_phase(input logic disarm);
    return disarm ? PH_W'(DISARM_LEN - 1) : PH_W'(ARM_LEN - 1);
  endfunction

  // Both patterns are zeros ending in a single one.
  function automatic logic code_bit(input logic [PH_W-1:0] ph, input logic [PH_W-1:0] last);
    return ph == last;
  endfunction

  function automatic logic [PH_W-1:0] step_phase(input logic [PH_W-1:0] ph, input logic [PH_W-1:0] last);
    return (ph == last) ? '0 : ph + 1'b1;
  endfunction

endpackage

// File: rtl/lbc_tx_gen.sv
module lbc_tx_gen
  import lbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       strobe,
  input  logic       bit_in,
  output logic       bit_out,
  output logic       payload_req,
  output logic       restart
);

  logic [1:0]      mode_q;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_eff;
  logic [PH_W-1:0] ph_last;

  assign restart     = (mode != mode_q);
  assign ph_last     = last_phase(mode[0]);
  assign ph_eff      = restart ? '0 : ph_q;
  assign bit_out     = mode[1] ? code_bit(ph_eff, ph_last) : bit_in;
  assign payload_req = (mode == 2'(LB_PAYLOAD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'(LB_NORMAL);
      ph_q   <= '0;
    end else begin
      mode_q <= mode;
      if (strobe) ph_q <= step_phase(ph_eff, ph_last);
      else        ph_q <= ph_eff;
    end
  end

endmodule

// File: rtl/lbc_rx_match.sv
module lbc_rx_match #(
  parameter int LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic bit_in,
  output logic hit
);

  localparam int HW = LEN - 1;

  logic [HW-1:0] hist_q;
  logic [LEN-1:0] window;

  assign window = {hist_q, bit_in};
  assign hit    = ($countones(window) == 1);

  always_ff @(posedge clk) begin
    if (!rst_n)      hist_q <= '1;
    else if (strobe) hist_q <= window[HW-1:0];
  end

endmodule

// File: rtl/lbc_run_qual.sv
module lbc_run_qual #(
  parameter int MIN_RUN_BITS = 5000,
  parameter int DROP_MISSES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic hit,
  output logic declared
);

  localparam int RUN_W  = $clog2(MIN_RUN_BITS + 1);
  localparam int MISS_W = $clog2(DROP_MISSES + 1);
  localparam logic [RUN_W-1:0]  RUN_TOP  = RUN_W'(MIN_RUN_BITS);
  localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(DROP_MISSES - 1);

  logic [RUN_W-1:0]  run_q;
  logic [MISS_W-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= '0;
      miss_q   <= '0;
      declared <= 1'b0;
    end else if (strobe) begin
      if (hit) begin
        miss_q <= '0;
        if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
        if (run_q == RUN_TOP - 1'b1) declared <= 1'b1;
      end else begin
        run_q <= '0;
        if (declared) begin
          if (miss_q == MISS_TOP) begin
            declared <= 1'b0;
            miss_q   <= '0;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/lbc_loop_code.sv
module lbc_loop_code
  import lbc_pkg::*;
#(
  parameter int MIN_RUN_BITS = 5000,
  parameter int DROP_MISSES  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lb_ctrl,
  input  logic       tx_strobe,
  input  logic       tx_bit_in,
  output logic       tx_bit_out,
  output logic       payload_lb,
  input  logic       rx_strobe,
  input  logic       rx_bit,
  output logic       act_detect,
  output logic       deact_detect
);

  localparam int N_CODES = 2;

  logic               tx_restart;
  logic [N_CODES-1:0] code_hit;
  logic [N_CODES-1:0] code_decl;

  lbc_tx_gen u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (lb_ctrl),
    .strobe     (tx_strobe),
    .bit_in     (tx_bit_in),
    .bit_out    (tx_bit_out),
    .payload_req(payload_lb),
    .restart    (tx_restart)
  );

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    localparam int LEN = (g == 0) ? ARM_LEN : DISARM_LEN;

    lbc_rx_match #(.LEN(LEN)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(rx_strobe),
      .bit_in(rx_bit),
      .hit   (code_hit[g])
    );

    lbc_run_qual #(.MIN_RUN_BITS(MIN_RUN_BITS), .DROP_MISSES(DROP_MISSES)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (rx_strobe),
      .hit     (code_hit[g]),
      .declared(code_decl[g])
    );
  end

  assign act_detect   = code_decl[0];
  assign deact_detect = code_decl[1] & ~code_decl[0];

endmodule

// File: rtl/lbc_loop_code_chk.sv
module lbc_loop_code_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] lb_ctrl,
  input logic       tx_strobe,
  input logic       tx_bit_out,
  input logic       tx_restart,
  input logic       rx_strobe,
  input logic       act_detect,
  input logic       deact_detect
);

  AST_ONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_detect && deact_detect)); // R10

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_restart && lb_ctrl[1]) |-> !tx_bit_out); // R6

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_ctrl[1] && !tx_strobe) |=> ((lb_ctrl != $past(lb_ctrl)) || $stable(tx_bit_out))); // R4

  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_strobe |=> ($stable(act_detect) && $stable(deact_detect))); // R11

  AST_ACT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_detect) |-> $past(rx_strobe)); // R8

  AST_ACT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_detect) |-> $past(rx_strobe)); // R9

endmodule

bind lbc_loop_code lbc_loop_code_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lb_ctrl     (lb_ctrl),
  .tx_strobe   (tx_strobe),
  .tx_bit_out  (tx_bit_out),
  .tx_restart  (tx_restart),
  .rx_strobe   (rx_strobe),
  .act_detect  (act_detect),
  .deact_detect(deact_detect)
);

// File: tb/lbc_loop_code_bench.sv
module lbc_loop_code_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_RUN    = 48;
  localparam int DROP       = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lb_ctrl = 2'b00;
  logic       tx_strobe = 1'b0, tx_bit_in = 1'b0;
  logic       rx_strobe = 1'b0, rx_bit = 1'b0;
  logic       tx_bit_out, payload_lb, act_detect, deact_detect;

  lbc_loop_code #(.MIN_RUN_BITS(MIN_RUN), .DROP_MISSES(DROP)) u_lbc_loop_code (
    .clk(clk), .rst_n(rst_n), .lb_ctrl(lb_ctrl), .tx_strobe(tx_strobe),
    .tx_bit_in(tx_bit_in), .tx_bit_out(tx_bit_out), .payload_lb(payload_lb),
    .rx_strobe(rx_strobe), .rx_bit(rx_bit), .act_detect(act_detect),
    .deact_detect(deact_detect)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench-side model state
  logic [1:0] m_prev = 2'b00;
  int         m_ph = 0;
  bit         m_hist[2][4];
  int         m_run[2], m_miss[2];
  bit         m_decl[2];
  logic [1:0] cur_mode = 2'b00;
  int         rx_idx = 0;

  task automatic chk(input string req, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int code_len(input int which);
    return (which == 0) ? 5 : 3;
  endfunction

  function automatic void model_reset();
    m_prev = 2'b00; m_ph = 0;
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 4; k++) m_hist[g][k] = 1'b1;
      m_run[g] = 0; m_miss[g] = 0; m_decl[g] = 0;
    end
  endfunction

  // history slot 0 is the newest previous bit
  function automatic void model_rx(input bit b);
    for (int g = 0; g < 2; g++) begin
      int len = code_len(g);
      int ones = b ? 1 : 0;
      for (int k = 0; k < len - 1; k++) ones += m_hist[g][k] ? 1 : 0;
      for (int k = 3; k > 0; k--) m_hist[g][k] = m_hist[g][k-1];
      m_hist[g][0] = b;
      if (ones == 1) begin
        m_miss[g] = 0;
        if (m_run[g] < MIN_RUN) m_run[g]++;
        if (m_run[g] == MIN_RUN) m_decl[g] = 1;
      end else begin
        m_run[g] = 0;
        if (m_decl[g]) begin
          m_miss[g]++;
          if (m_miss[g] == DROP) begin m_decl[g] = 0; m_miss[g] = 0; end
        end
      end
    end
  endfunction

  // called just after a falling edge; one clock cycle per call
  task automatic apply(input logic [1:0] c, input logic ts, input logic tb,
                       input logic rs, input logic rb, input string rreq);
    int    eff, len;
    logic  etx;
    string treq;
    lb_ctrl = c; tx_strobe = ts; tx_bit_in = tb; rx_strobe = rs; rx_bit = rb;
    #1;
    len = c[0] ? 3 : 5;
    eff = (c != m_prev) ? 0 : m_ph;
    etx = c[1] ? (eff == len - 1) : tb;
    case (c)
      2'b00: treq = "R2";
      2'b01: treq = "R3";
      2'b10: treq = (c != m_prev) ? "R6" : "R4";
      default: treq = (c != m_prev) ? "R6" : "R5";
    endcase
    chk(treq, tx_bit_out, etx);
    chk(c == 2'b01 ? "R3" : "R2", payload_lb, c == 2'b01);
    m_ph = ts ? ((eff == len - 1) ? 0 : eff + 1) : eff;
    m_prev = c;
    if (rs) model_rx(rb);
    @(negedge clk);
    chk(rreq, act_detect, m_decl[0]);
    chk(rreq, deact_detect, m_decl[1] && !m_decl[0]);
    chk("R10", act_detect && deact_detect, 1'b0);
  endtask

  // kind: 0 activate code, 1 deactivate code, 2 ones, 3 zeros, 4 random
  task automatic feed(input int kind, input int nbits, input int err_every,
                      input int mode_every, input string rreq);
    int sent = 0;
    while (sent < nbits) begin
      logic rs = ($urandom % 4) != 0;
      logic rb = 1'b0;
      if (mode_every > 0 && ($urandom % mode_every) == 0) cur_mode = 2'($urandom);
      if (rs) begin
        case (kind)
          0: rb = (rx_idx % 5) == 4;
          1: rb = (rx_idx % 3) == 2;
          2: rb = 1'b1;
          3: rb = 1'b0;
          default: rb = 1'($urandom);
        endcase
        if (err_every > 0 && (sent % err_every) == err_every - 1) rb = ~rb;
        rx_idx++;
        sent++;
      end
      apply(cur_mode, 1'($urandom), 1'($urandom), rs, rb, rreq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b5e_0c0d));
    model_reset();
    repeat (4) @(negedge clk);
    chk("R1", act_detect, 1'b0);
    chk("R1", deact_detect, 1'b0);
    tx_bit_in = 1'b1; #1;
    chk("R1", tx_bit_out, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    apply(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, "R1");

    // directed transmit: activate then switch mid-pattern to deactivate
    for (int i = 0; i < 12; i++) apply(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 3; i++)  apply(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 8; i++)  apply(2'b11, i[0], 1'b0, 1'b0, 1'b0, "R11");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    apply(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    apply(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, "R3");

    // activate declaration, then miss boundary
    cur_mode = 2'b10; rx_idx = 0;
    feed(0, MIN_RUN + 10, 0, 0, "R8");
    chk("R8", act_detect, 1'b1);
    feed(2, DROP - 1, 0, 0, "R9");
    chk("R9", act_detect, 1'b1);
    feed(2, 1, 0, 0, "R9");
    chk("R9", act_detect, 1'b0);

    // deactivate declaration, then activate stream takes priority
    rx_idx = 0; cur_mode = 2'b11;
    feed(1, MIN_RUN + 5, 0, 0, "R8");
    chk("R8", deact_detect, 1'b1);
    rx_idx = 0;
    feed(0, MIN_RUN + 5, 0, 0, "R10");
    chk("R10", act_detect, 1'b1);
    chk("R10", deact_detect, 1'b0);

    // all zeros withdraws both codes
    feed(3, 100, 0, 0, "R9");
    chk("R9", act_detect, 1'b0);
    chk("R9", deact_detect, 1'b0);

    // periodic single errors keep the run from completing
    rx_idx = 0;
    feed(0, 4 * MIN_RUN, 30, 0, "R7");
    chk("R7", act_detect, 1'b0);

    // random bits and random mode changes
    feed(4, 3000, 0, 15, "R7");
    rx_idx = 0;
    feed(1, 2 * MIN_RUN, 0, 10, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule